// File: doc/BRIEF.md
# Trace Cache with Fill Unit

An instruction supply cache that keeps instructions in the order they actually executed rather than in address order. Each line is keyed by the address where its trace begins. A line holds up to eight instructions, even when those instructions run across taken branches. It also records the outcome of every branch inside the trace and the address to fetch after the trace. Because of this, one lookup hit gives the execution core a wide block of instructions and also acts as a branch prediction.

The block works in two modes. In stream mode, a fetch address that matches a valid line returns the whole trace in the same cycle, together with its path information. In build mode, which starts after a lookup miss, a fill unit gathers the instructions that come out of the decoder. It records each instruction's branch flag and outcome into a pending trace. When the pending trace reaches its instruction limit or its branch limit, the fill unit writes it into the line selected by the trace's start address. A flush input removes every stored line and any trace still being gathered.

Top module: `trace_cache`

## Requirements
- R1: After reset, no lookup hits, `hit_count` is 0 and `build_mode` is 0.
- R2: When `fetch_valid` is 1 and a valid line holds the same start address (bits 1:0 ignored), `hit` is 1 in that same cycle. The trace outputs then carry that line's contents, with instruction slot i on `hit_instrs[32*i +: 32]`. On any cycle without a hit, every trace output is 0.
- R3: A miss while no trace is being gathered sets `build_mode` to 1 from the next cycle, and the new trace starts at the missed address. While gathering, further misses do not restart the trace. Decoder input that arrives while `build_mode` is 0 is discarded.
- R4: A trace closes when it holds 8 instructions. The line can be looked up from the cycle after the closing instruction arrives, and its next fetch address is the `dec_next_pc` of the closing instruction.
- R5: A trace also closes on its 3rd branch. Bit k of `hit_br_taken` is the taken flag of the k-th branch in trace order, and `hit_br_count` is the number of branches.
- R6: `hit_ends_br` is 1 exactly when the last instruction of the trace is a branch. A trace closed by length records its branch count and taken flags in the same way.
- R7: Lines are direct-mapped over 32 entries, indexed by address bits 6:2. When a new trace is written to an occupied index, it replaces the old line, and the old start address then misses.
- R8: `flush` clears every line and drops any partial trace. From the next cycle nothing hits, `build_mode` is 0, and decoder input is discarded.
- R9: Instruction slots at or beyond `hit_count` read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all lines and the partial trace |
| fetch_valid | input | 1 | Lookup request |
| fetch_addr | input | 32 | Lookup address |
| hit | output | 1 | Lookup matched a valid line |
| hit_count | output | 4 | Number of instructions delivered |
| hit_instrs | output | 256 | Trace instructions, slot 0 in the low bits |
| hit_next_addr | output | 32 | Fetch address following the trace |
| hit_br_taken | output | 3 | Taken flag for each branch, in trace order |
| hit_br_count | output | 2 | Number of branches in the trace |
| hit_ends_br | output | 1 | Trace ends with a branch |
| build_mode | output | 1 | Fill unit is gathering a trace |
| dec_valid | input | 1 | Decoder instruction present |
| dec_instr | input | 32 | Decoded instruction |
| dec_is_br | input | 1 | Instruction is a branch |
| dec_taken | input | 1 | Branch outcome |
| dec_next_pc | input | 32 | Address executed after this instruction |

## Verification
The bench builds the block with its default parameters: eight instructions per line, a limit of three branches, and 32 lines. With those values, both ways of closing a trace can be reached in just a few decoder beats. A line that ends short shows its zeroed tail slots. Two start addresses that differ only in bit 7 collide on index 0, which exercises replacement. A behavioural model keeps the lines and the pending trace in queues and is compared against every output on every cycle. This covers misses that arrive during gathering, decoder beats that arrive while idle, and a flush in the middle of a trace.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [0:0] {
    FILL_IDLE  = 1'b0,
    FILL_BUILD = 1'b1
  } fill_state_e;
endpackage

// File: rtl/tc_fill_unit.sv
module tc_fill_unit #(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int LINE_INSTR = 8,
  parameter int MAX_BR     = 3,
  parameter int IDX_W      = 5,
  parameter int IDX_LO     = 2,
  localparam int CNT_W     = $clog2(LINE_INSTR + 1),
  localparam int BRC_W     = $clog2(MAX_BR + 1),
  localparam int TAG_W     = ADDR_W - IDX_LO - IDX_W,
  localparam int DATA_W    = LINE_INSTR * INSTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              miss,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              dec_valid,
  input  logic [INSTR_W-1:0] dec_instr,
  input  logic              dec_is_br,
  input  logic              dec_taken,
  input  logic [ADDR_W-1:0] dec_next_pc,
  output logic              building,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  wr_count,
  output logic [ADDR_W-1:0] wr_next,
  output logic [MAX_BR-1:0] wr_brt,
  output logic [BRC_W-1:0]  wr_brc,
  output logic              wr_end
);
  import tc_pkg::*;

  fill_state_e       state_q, state_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [BRC_W-1:0]  brc_q, brc_d, brc_inc;
  logic [MAX_BR-1:0] brt_q, brt_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              take, open_trace, data_en;

  always_comb begin
    state_d    = state_q;
    start_d    = start_q;
    cnt_d      = cnt_q;
    brc_d      = brc_q;
    brt_d      = brt_q;
    buf_d      = buf_q;
    wr_en      = 1'b0;
    open_trace = 1'b0;
    take       = (state_q == FILL_BUILD) && dec_valid;
    cnt_inc    = cnt_q + 1'b1;
    brc_inc    = brc_q + BRC_W'(dec_is_br);
    if (take) begin
      for (int s = 0; s < LINE_INSTR; s++) begin
        if (cnt_q == CNT_W'(s)) buf_d[s*INSTR_W +: INSTR_W] = dec_instr;
      end
      for (int b = 0; b < MAX_BR; b++) begin
        if (dec_is_br && (brc_q == BRC_W'(b))) brt_d[b] = dec_taken;
      end
      cnt_d = cnt_inc;
      brc_d = brc_inc;
      if ((cnt_inc == CNT_W'(LINE_INSTR)) || (brc_inc == BRC_W'(MAX_BR))) begin
        wr_en   = 1'b1;
        state_d = FILL_IDLE;
      end
    end else if ((state_q == FILL_IDLE) && miss) begin
      open_trace = 1'b1;
      state_d    = FILL_BUILD;
      start_d    = miss_addr;
      cnt_d      = '0;
      brc_d      = '0;
      brt_d      = '0;
      buf_d      = '0;
    end
    if (flush) begin
      state_d = FILL_IDLE;
      wr_en   = 1'b0;
    end
  end

  assign data_en = (take || open_trace) && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FILL_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      start_q <= start_d;
      cnt_q   <= cnt_d;
      brc_q   <= brc_d;
      brt_q   <= brt_d;
      buf_q   <= buf_d;
    end
  end

  assign building = (state_q == FILL_BUILD);
  assign wr_idx   = start_q[IDX_LO +: IDX_W];
  assign wr_tag   = start_q[ADDR_W-1 -: TAG_W];
  assign wr_data  = buf_d;
  assign wr_count = cnt_d;
  assign wr_next  = dec_next_pc;
  assign wr_brt   = brt_d;
  assign wr_brc   = brc_d;
  assign wr_end   = dec_is_br;
endmodule

// File: rtl/tc_line_store.sv
module tc_line_store #(
  parameter int NUM_LINES = 32,
  parameter int REC_W     = 64,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REC_W-1:0] wr_rec,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [REC_W-1:0] rd_rec
);
  logic [NUM_LINES-1:0] valid_a;
  logic [REC_W-1:0]     rec_a [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic             sel;
    logic             valid_q;
    logic [REC_W-1:0] rec_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q <= 1'b0;
      else if (flush) valid_q <= 1'b0;
      else if (sel)   valid_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) rec_q <= wr_rec;
    end

    assign valid_a[g] = valid_q;
    assign rec_a[g]   = rec_q;
  end

  assign rd_valid = valid_a[rd_idx];
  assign rd_rec   = rec_a[rd_idx];
endmodule

// File: rtl/tc_hit_compare.sv
module tc_hit_compare #(
  parameter int TAG_W = 25,
  parameter int PAY_W = 64
) (
  input  logic             fetch_valid,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [PAY_W-1:0] line_pay,
  output logic             hit,
  output logic [PAY_W-1:0] pay_out
);
  assign hit     = fetch_valid && line_valid && (line_tag == fetch_tag);
  assign pay_out = hit ? line_pay : '0;
endmodule

// File: rtl/trace_cache.sv
module trace_cache #(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int LINE_INSTR = 8,
  parameter int MAX_BR     = 3,
  parameter int NUM_LINES  = 32,
  parameter int IDX_LO     = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                flush,
  input  logic                                fetch_valid,
  input  logic [ADDR_W-1:0]                   fetch_addr,
  output logic                                hit,
  output logic [$clog2(LINE_INSTR+1)-1:0]     hit_count,
  output logic [LINE_INSTR*INSTR_W-1:0]       hit_instrs,
  output logic [ADDR_W-1:0]                   hit_next_addr,
  output logic [MAX_BR-1:0]                   hit_br_taken,
  output logic [$clog2(MAX_BR+1)-1:0]         hit_br_count,
  output logic                                hit_ends_br,
  output logic                                build_mode,
  input  logic                                dec_valid,
  input  logic [INSTR_W-1:0]                  dec_instr,
  input  logic                                dec_is_br,
  input  logic                                dec_taken,
  input  logic [ADDR_W-1:0]                   dec_next_pc
);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int CNT_W  = $clog2(LINE_INSTR + 1);
  localparam int BRC_W  = $clog2(MAX_BR + 1);
  localparam int TAG_W  = ADDR_W - IDX_LO - IDX_W;
  localparam int DATA_W = LINE_INSTR * INSTR_W;
  localparam int PAY_W  = DATA_W + CNT_W + ADDR_W + MAX_BR + BRC_W + 1;
  localparam int REC_W  = TAG_W + PAY_W;

  logic              wr_en, wr_end, line_valid, miss;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag, line_tag;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  wr_count;
  logic [ADDR_W-1:0] wr_next;
  logic [MAX_BR-1:0] wr_brt;
  logic [BRC_W-1:0]  wr_brc;
  logic [REC_W-1:0]  wr_rec, rd_rec;
  logic [PAY_W-1:0]  line_pay, pay_out;

  assign miss = fetch_valid && !hit;

  tc_fill_unit #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .LINE_INSTR(LINE_INSTR),
    .MAX_BR(MAX_BR), .IDX_W(IDX_W), .IDX_LO(IDX_LO)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .miss(miss), .miss_addr(fetch_addr),
    .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_is_br(dec_is_br),
    .dec_taken(dec_taken), .dec_next_pc(dec_next_pc),
    .building(build_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .wr_count(wr_count), .wr_next(wr_next), .wr_brt(wr_brt),
    .wr_brc(wr_brc), .wr_end(wr_end)
  );

  assign wr_rec = {wr_tag, wr_data, wr_count, wr_next, wr_brt, wr_brc, wr_end};

  tc_line_store #(
    .NUM_LINES(NUM_LINES), .REC_W(REC_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_rec(wr_rec),
    .rd_idx(fetch_addr[IDX_LO +: IDX_W]),
    .rd_valid(line_valid), .rd_rec(rd_rec)
  );

  assign line_tag = rd_rec[REC_W-1 -: TAG_W];
  assign line_pay = rd_rec[PAY_W-1:0];

  tc_hit_compare #(
    .TAG_W(TAG_W), .PAY_W(PAY_W)
  ) u_cmp (
    .fetch_valid(fetch_valid), .fetch_tag(fetch_addr[ADDR_W-1 -: TAG_W]),
    .line_valid(line_valid), .line_tag(line_tag), .line_pay(line_pay),
    .hit(hit), .pay_out(pay_out)
  );

  assign {hit_instrs, hit_count, hit_next_addr, hit_br_taken, hit_br_count, hit_ends_br} = pay_out;
endmodule

// File: rtl/trace_cache_chk.sv
module trace_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int LINE_INSTR = 8,
  parameter int MAX_BR     = 3,
  parameter int NUM_LINES  = 32,
  parameter int IDX_LO     = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            flush,
  input logic                            fetch_valid,
  input logic [ADDR_W-1:0]               fetch_addr,
  input logic                            hit,
  input logic [$clog2(LINE_INSTR+1)-1:0] hit_count,
  input logic [LINE_INSTR*INSTR_W-1:0]   hit_instrs,
  input logic [ADDR_W-1:0]               hit_next_addr,
  input logic [MAX_BR-1:0]               hit_br_taken,
  input logic [$clog2(MAX_BR+1)-1:0]     hit_br_count,
  input logic                            hit_ends_br,
  input logic                            build_mode,
  input logic                            dec_valid,
  input logic [INSTR_W-1:0]              dec_instr,
  input logic                            dec_is_br,
  input logic                            dec_taken,
  input logic [ADDR_W-1:0]               dec_next_pc
);
  assert_hit_needs_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> fetch_valid);

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_count == '0 && hit_next_addr == '0 && hit_instrs == '0));

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_count != '0 && int'(hit_count) <= LINE_INSTR));

  assert_branch_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(hit_br_count) <= MAX_BR &&
             $countones(hit_br_taken) <= int'(hit_br_count)));

  assert_end_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_ends_br) |-> (hit_br_count != '0));

  assert_build_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(build_mode) |-> $past(fetch_valid && !hit && !flush));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!hit && !build_mode));
endmodule

bind trace_cache trace_cache_chk #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .LINE_INSTR(LINE_INSTR),
  .MAX_BR(MAX_BR), .NUM_LINES(NUM_LINES), .IDX_LO(IDX_LO)
) u_chk (.*);

// File: tb/trace_cache_tb.sv
module trace_cache_tb;
  logic         clk, rst_n, flush, fetch_valid;
  logic [31:0]  fetch_addr;
  logic         hit, hit_ends_br, build_mode;
  logic [3:0]   hit_count;
  logic [255:0] hit_instrs;
  logic [31:0]  hit_next_addr;
  logic [2:0]   hit_br_taken;
  logic [1:0]   hit_br_count;
  logic         dec_valid, dec_is_br, dec_taken;
  logic [31:0]  dec_instr, dec_next_pc;

  int checks = 0, errors = 0;
  bit done = 0;

  trace_cache u_dut (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  // reference model
  bit          m_valid [32];
  logic [31:0] m_addr  [32];
  int          m_cnt   [32];
  logic [31:0] m_next  [32];
  logic [2:0]  m_brt   [32];
  int          m_brc   [32];
  bit          m_end   [32];
  logic [31:0] m_ins   [32][8];
  bit          p_build;
  logic [31:0] p_start;
  logic [31:0] p_ins [$];
  bit          p_br  [$];
  bit          last_eh;

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int idx;
    bit eh;
    logic [255:0] ev;
    idx = int'(fetch_addr[6:2]);
    eh  = fetch_valid && m_valid[idx] && (m_addr[idx][31:7] == fetch_addr[31:7]);
    last_eh = eh;
    ev = '0;
    if (eh) for (int s = 0; s < 8; s++) ev[s*32 +: 32] = m_ins[idx][s];
    chk(tag, "hit", 256'(hit), 256'(eh));
    chk(tag, "count", 256'(hit_count), eh ? 256'(m_cnt[idx]) : 256'(0));
    chk(tag, "next", 256'(hit_next_addr), eh ? 256'(m_next[idx]) : 256'(0));
    chk(tag, "br_taken", 256'(hit_br_taken), eh ? 256'(m_brt[idx]) : 256'(0));
    chk(tag, "br_count", 256'(hit_br_count), eh ? 256'(m_brc[idx]) : 256'(0));
    chk(tag, "ends_br", 256'(hit_ends_br), eh ? 256'(m_end[idx]) : 256'(0));
    chk(tag, "instrs", hit_instrs, ev);
    chk(tag, "build_mode", 256'(build_mode), 256'(p_build));
  endtask

  task automatic model_update();
    int idx;
    if (flush) begin
      for (int i = 0; i < 32; i++) m_valid[i] = 0;
      p_build = 0;
      p_ins.delete();
      p_br.delete();
    end else if (p_build && dec_valid) begin
      p_ins.push_back(dec_instr);
      if (dec_is_br) p_br.push_back(dec_taken);
      if (p_ins.size() == 8 || p_br.size() == 3) begin
        idx = int'(p_start[6:2]);
        m_valid[idx] = 1;
        m_addr[idx]  = p_start;
        m_cnt[idx]   = p_ins.size();
        m_next[idx]  = dec_next_pc;
        m_brc[idx]   = p_br.size();
        m_end[idx]   = dec_is_br;
        m_brt[idx]   = '0;
        for (int b = 0; b < p_br.size(); b++) m_brt[idx][b] = p_br[b];
        for (int s = 0; s < 8; s++) m_ins[idx][s] = (s < p_ins.size()) ? p_ins[s] : 32'h0;
        p_build = 0;
      end
    end else if (!p_build && fetch_valid && !last_eh) begin
      p_build = 1;
      p_start = fetch_addr;
      p_ins.delete();
      p_br.delete();
    end
  endtask

  task automatic pre(string tag);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic post();
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic cyc(string tag);
    pre(tag);
    post();
  endtask

  task automatic idle_in();
    fetch_valid = 0; fetch_addr = 0; flush = 0;
    dec_valid = 0; dec_instr = 0; dec_is_br = 0; dec_taken = 0; dec_next_pc = 0;
  endtask

  task automatic feed(logic [31:0] ins, bit br, bit tk, logic [31:0] nxt, string tag);
    dec_valid = 1; dec_instr = ins; dec_is_br = br; dec_taken = tk; dec_next_pc = nxt;
    cyc(tag);
    dec_valid = 0; dec_is_br = 0; dec_taken = 0;
  endtask

  task automatic lookup_miss(logic [31:0] a, string tag);
    fetch_valid = 1; fetch_addr = a;
    pre(tag);
    chk(tag, "directed miss", 256'(hit), 256'(0));
    chk(tag, "directed miss count", 256'(hit_count), 256'(0));
    post();
    fetch_valid = 0;
  endtask

  localparam logic [31:0] A = 32'h0000_1000;
  localparam logic [31:0] B = 32'h0000_2044;
  localparam logic [31:0] C = 32'h0000_3008;
  localparam logic [31:0] D = 32'h0000_1080;
  localparam logic [31:0] E = 32'h0000_4010;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in();
    rst_n = 0;
    p_build = 0;
    for (int i = 0; i < 32; i++) m_valid[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    fetch_valid = 1; fetch_addr = A;
    pre("R1");
    chk("R1", "reset hit", 256'(hit), 256'(0));
    chk("R1", "reset build_mode", 256'(build_mode), 256'(0));
    fetch_valid = 0;
    #1;
    // R3: decoder beat while idle is discarded (fetch deasserted before edge)
    dec_valid = 1; dec_instr = 32'hDEAD_0000;
    post();
    dec_valid = 0;

    // R3: miss starts build
    lookup_miss(A, "R3");
    pre("R3");
    chk("R3", "build after miss", 256'(build_mode), 256'(1));
    post();

    // R4: eight sequential instructions close the trace
    for (int k = 0; k < 8; k++) feed(32'hA000_0000 + k, 0, 0, A + 32'(4 * (k + 1)), "R4");
    fetch_valid = 1; fetch_addr = A;
    pre("R4");
    chk("R4", "A count", 256'(hit_count), 256'(8));
    chk("R4", "A next", 256'(hit_next_addr), 256'(A + 32));
    chk("R3", "A slot0 skips idle beat", 256'(hit_instrs[31:0]), 256'(32'hA000_0000));
    chk("R2", "A slot7", 256'(hit_instrs[255:224]), 256'(32'hA000_0007));
    post();
    fetch_valid = 0;

    // R5: third branch closes the trace
    lookup_miss(B, "R5");
    feed(32'hB000_0000, 0, 0, B + 4, "R5");
    feed(32'hB000_0001, 1, 1, 32'h0000_2100, "R5");
    feed(32'hB000_0002, 0, 0, 32'h0000_2104, "R5");
    feed(32'hB000_0003, 1, 0, 32'h0000_2108, "R5");
    feed(32'hB000_0004, 1, 1, 32'h0000_2200, "R5");
    fetch_valid = 1; fetch_addr = B;
    pre("R5");
    chk("R5", "B count", 256'(hit_count), 256'(5));
    chk("R5", "B br_taken", 256'(hit_br_taken), 256'(3'b101));
    chk("R5", "B br_count", 256'(hit_br_count), 256'(3));
    chk("R6", "B ends_br", 256'(hit_ends_br), 256'(1));
    chk("R4", "B next", 256'(hit_next_addr), 256'(32'h0000_2200));
    chk("R9", "B tail slots", 256'(hit_instrs[255:160]), 256'(0));
    post();
    fetch_valid = 0;

    // R6: length-closed trace with one branch
    lookup_miss(C, "R6");
    feed(32'hC000_0000, 1, 1, 32'h0000_3400, "R6");
    for (int k = 1; k < 8; k++) feed(32'hC000_0000 + k, 0, 0, 32'h0000_3400 + 32'(4 * k), "R6");
    fetch_valid = 1; fetch_addr = C;
    pre("R6");
    chk("R6", "C count", 256'(hit_count), 256'(8));
    chk("R6", "C br_count", 256'(hit_br_count), 256'(1));
    chk("R6", "C br_taken", 256'(hit_br_taken), 256'(3'b001));
    chk("R6", "C ends_br", 256'(hit_ends_br), 256'(0));
    post();
    fetch_valid = 0;

    // R7 and R3: replacement at index 0; a miss during build does not restart
    lookup_miss(D, "R7");
    for (int k = 0; k < 4; k++) feed(32'hD000_0000 + k, 0, 0, D + 32'(4 * (k + 1)), "R7");
    lookup_miss(E, "R3");
    pre("R3");
    chk("R3", "still building", 256'(build_mode), 256'(1));
    post();
    for (int k = 4; k < 8; k++) feed(32'hD000_0000 + k, 0, 0, D + 32'(4 * (k + 1)), "R7");
    fetch_valid = 1; fetch_addr = D;
    pre("R7");
    chk("R7", "D hit", 256'(hit), 256'(1));
    chk("R3", "D slot4 continues", 256'(hit_instrs[159:128]), 256'(32'hD000_0004));
    post();
    fetch_valid = 0;
    lookup_miss(A, "R7");   // A replaced; this miss starts a build at A

    // R8: flush mid-trace
    for (int k = 0; k < 3; k++) feed(32'hF000_0000 + k, 0, 0, A + 32'(4 * (k + 1)), "R8");
    flush = 1;
    cyc("R8");
    flush = 0;
    pre("R8");
    chk("R8", "build after flush", 256'(build_mode), 256'(0));
    post();
    for (int k = 0; k < 8; k++) feed(32'hF100_0000 + k, 0, 0, A + 32'(4 * k), "R8");
    fetch_valid = 1; fetch_addr = B;
    pre("R8");
    chk("R8", "B gone", 256'(hit), 256'(0));
    post();
    fetch_valid = 0;
    lookup_miss(C, "R8");
    repeat (2) cyc("R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule